// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the control core of a microcoded processor. A control address register selects one word of an internal read-only control store. The selected word acts as the control buffer: its control field drives the control lines straight out, and its next-address fields steer the sequencer. One clock period covers three steps. The word is read, the next address is decided from the word and the live inputs, and that address is loaded into the register. Reset puts the register at the fetch routine and clears the one-deep return link.

The next address comes from one of six encoded choices held in the word's 3-bit select field:

| Code | Name | Effect on the next address |
|------|------|----------------------------|
| 0 | `NX_SEQ` | step to the following word |
| 1 | `NX_COND` | branch on a 2-bit condition field |
| 2 | `NX_MAP` | jump to the routine for the opcode |
| 3 | `NX_CALL` | call a microsubroutine and record the return point |
| 4 | `NX_RET` | return through the link |
| 5 | `NX_ITEST` | enter the interrupt routine if a request is pending |
| 6, 7 | `NX_RSV6`, `NX_RSV7` | reserved, behave like stepping |

The condition field picks one of four tests:

| Code | Name | Test |
|------|------|------|
| 0 | `CN_ALWAYS` | always true |
| 1 | `CN_ZERO` | zero flag |
| 2 | `CN_OVF` | overflow flag |
| 3 | `CN_IND` | indirect bit |

The surrounding datapath samples the control lines. It supplies the opcode, the ALU flags, the indirect bit and the interrupt request.

The built-in microprogram has five parts:

- Fetch: 0x00 and 0x01 step. 0x02 branches to 0x08 on the indirect bit. 0x03 maps the opcode.
- Indirect: 0x08 steps, then 0x09 jumps back to 0x03.
- Interrupt: 0x0C steps, then 0x0D jumps to 0x00.
- Subroutine: 0xF0 steps, then 0xF1 returns.
- Opcode routines: eight words each, starting at 0x20 + 8·opcode.

Top module: `uc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the control address becomes 0x00 (fetch entry) and the link clears; `uaddr` reads 0x00 and `ctrl_lines` reads 0x00A5.
- R2: `ctrl_lines` always equals the control field of the word at `uaddr`, which for address a is {a, a XOR 0xA5}.
- R3: Select code 0 (sequential) loads address + 1.
- R4: Select code 1 (conditional) loads the word's target field when its condition is true, else address + 1. The condition codes are 0 always, 1 `flag_zero`, 2 `flag_ovf` and 3 `ind_bit`.
- R5: Select code 2 (map) loads 0x20 + 8·`opcode` from the 16-entry opcode map.
- R6: Select code 3 (call) loads the target field and stores address + 1 in the link.
- R7: Select code 4 (return) loads the link.
- R8: Select code 5 (interrupt test) loads 0x0C when `irq_req` is high, else address + 1.
- R9: Select codes 6 and 7 behave exactly as code 0.
- R10: Microprogram layout, part 1. 0x00 and 0x01 step, 0x02 tests the indirect bit to 0x08, 0x03 maps, 0x08 steps, 0x09 jumps to 0x03, 0x0C steps, 0x0D jumps to 0x00, 0xF0 steps, 0xF1 returns, and all other words step.
- R12: Microprogram layout, part 2, for the routine of opcode k at base B = 0x20 + 8k:
  - B+0 is conditional, with condition code k mod 4 and target B+4.
  - B+1 uses code 0 for even k, code 6 when k mod 4 = 1 and code 7 when k mod 4 = 3.
  - B+2 calls 0xF0.
  - B+3 is an interrupt test.
  - B+4 jumps unconditionally to 0x00.
- R11: The next address depends on the inputs present before the rising edge and appears on `uaddr` after that single edge, with no extra latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, rising edge active |
| rst | input | 1 | synchronous reset, active high |
| opcode | input | 4 | machine opcode used by the map choice |
| flag_zero | input | 1 | ALU zero flag |
| flag_ovf | input | 1 | ALU overflow flag |
| ind_bit | input | 1 | indirect-address bit of the instruction |
| irq_req | input | 1 | pending interrupt request |
| ctrl_lines | output | 16 | control field of the current word |
| uaddr | output | 8 | current control address |

## Verification
The properties assume two things about the inputs. All of them are valid 0/1 values at each rising edge. A return is reached only after a call made since reset, so the link holds a meaningful address. The stimulus drives every input at falling edges from directed patterns or from a seeded random source, so each input is stable and known when it is sampled. Only the built-in microprogram is executed, and in it every return follows a call. Random opcodes, flags and interrupt requests carry the sequencer through every routine, every condition code and both outcomes of each test.

// File: rtl/uc_pkg.sv
package uc_pkg;

    localparam int UA_W      = 8;
    localparam int CTL_W     = 2 * UA_W;
    localparam int OPC_W     = 4;
    localparam int MAP_SHIFT = 3;
    localparam int MAP_N     = 1 << OPC_W;
    localparam int ROUT_SPAN = MAP_N << MAP_SHIFT;

    localparam logic [UA_W-1:0] FETCH_ENTRY = 8'h00;
    localparam logic [UA_W-1:0] IND_TEST    = 8'h02;
    localparam logic [UA_W-1:0] DECODE_ADDR = 8'h03;
    localparam logic [UA_W-1:0] IND_ENTRY   = 8'h08;
    localparam logic [UA_W-1:0] IND_BACK    = 8'h09;
    localparam logic [UA_W-1:0] INT_ENTRY   = 8'h0C;
    localparam logic [UA_W-1:0] INT_BACK    = 8'h0D;
    localparam logic [UA_W-1:0] SUB_ENTRY   = 8'hF0;
    localparam logic [UA_W-1:0] SUB_BACK    = 8'hF1;
    localparam logic [UA_W-1:0] MAP_BASE    = 8'h20;
    localparam logic [UA_W-1:0] CTL_MASK    = 8'hA5;

    typedef enum logic [2:0] {
        NX_SEQ   = 3'd0,
        NX_COND  = 3'd1,
        NX_MAP   = 3'd2,
        NX_CALL  = 3'd3,
        NX_RET   = 3'd4,
        NX_ITEST = 3'd5,
        NX_RSV6  = 3'd6,
        NX_RSV7  = 3'd7
    } nx_sel_e;

    typedef enum logic [1:0] {
        CN_ALWAYS = 2'd0,
        CN_ZERO   = 2'd1,
        CN_OVF    = 2'd2,
        CN_IND    = 2'd3
    } cnd_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        nx_sel_e          sel;
        cnd_e             cnd;
        logic [UA_W-1:0]  tgt;
    } uword_t;

    function automatic logic [UA_W-1:0] map_entry(input logic [OPC_W-1:0] opc);
        return MAP_BASE + (UA_W'(opc) << MAP_SHIFT);
    endfunction

    // Built-in microprogram: one word per control address.
    function automatic uword_t ucode(input logic [UA_W-1:0] a);
        uword_t           w;
        logic [UA_W-1:0]  rel;
        logic [OPC_W-1:0] k;
        w.ctl = {a, a ^ CTL_MASK};
        w.sel = NX_SEQ;
        w.cnd = CN_ALWAYS;
        w.tgt = '0;
        rel   = a - MAP_BASE;
        k     = OPC_W'(rel >> MAP_SHIFT);
        if (int'(a) >= int'(MAP_BASE) && int'(a) < int'(MAP_BASE) + ROUT_SPAN) begin
            case (rel[MAP_SHIFT-1:0])
                3'd0: begin
                    w.sel = NX_COND;
                    w.cnd = cnd_e'(k[1:0]);
                    w.tgt = a + 8'd4;
                end
                3'd1: w.sel = k[0] ? (k[1] ? NX_RSV7 : NX_RSV6) : NX_SEQ;
                3'd2: begin
                    w.sel = NX_CALL;
                    w.tgt = SUB_ENTRY;
                end
                3'd3: w.sel = NX_ITEST;
                3'd4: begin
                    w.sel = NX_COND;
                    w.tgt = FETCH_ENTRY;
                end
                default: w.sel = NX_SEQ;
            endcase
        end else begin
            case (a)
                IND_TEST: begin
                    w.sel = NX_COND;
                    w.cnd = CN_IND;
                    w.tgt = IND_ENTRY;
                end
                DECODE_ADDR: w.sel = NX_MAP;
                IND_BACK: begin
                    w.sel = NX_COND;
                    w.tgt = DECODE_ADDR;
                end
                INT_BACK: begin
                    w.sel = NX_COND;
                    w.tgt = FETCH_ENTRY;
                end
                SUB_BACK: w.sel = NX_RET;
                default:  w.sel = NX_SEQ;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/uc_store.sv
module uc_store
    import uc_pkg::*;
#(
    parameter int DEPTH = 1 << UA_W
) (
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);

    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        assign rom[i] = ucode(UA_W'(i));
    end

    assign word = rom[addr];

endmodule

// File: rtl/uc_link.sv
module uc_link
    import uc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            save,
    input  logic [UA_W-1:0] ret_in,
    output logic [UA_W-1:0] link
);

    always_ff @(posedge clk) begin
        if (rst) begin
            link <= '0;
        end else if (save) begin
            link <= ret_in;
        end
    end

endmodule

// File: rtl/uc_nextaddr.sv
module uc_nextaddr
    import uc_pkg::*;
(
    input  logic [UA_W-1:0]  car,
    input  nx_sel_e          sel,
    input  cnd_e             cnd,
    input  logic [UA_W-1:0]  tgt,
    input  logic [UA_W-1:0]  link,
    input  logic [OPC_W-1:0] opcode,
    input  logic             flag_zero,
    input  logic             flag_ovf,
    input  logic             ind_bit,
    input  logic             irq_req,
    output logic [UA_W-1:0]  nxt,
    output logic             save_link,
    output logic [UA_W-1:0]  ret_addr
);

    logic [UA_W-1:0] map_tab [MAP_N];
    logic [UA_W-1:0] inc;
    logic            cond_true;

    for (genvar j = 0; j < MAP_N; j++) begin : g_map
        assign map_tab[j] = map_entry(OPC_W'(j));
    end

    assign inc      = car + 1'b1;
    assign ret_addr = inc;

    always_comb begin
        unique case (cnd)
            CN_ALWAYS: cond_true = 1'b1;
            CN_ZERO:   cond_true = flag_zero;
            CN_OVF:    cond_true = flag_ovf;
            CN_IND:    cond_true = ind_bit;
        endcase
    end

    always_comb begin
        save_link = 1'b0;
        nxt       = inc;
        unique case (sel)
            NX_SEQ, NX_RSV6, NX_RSV7: nxt = inc;
            NX_COND:  nxt = cond_true ? tgt : inc;
            NX_MAP:   nxt = map_tab[opcode];
            NX_CALL: begin
                nxt       = tgt;
                save_link = 1'b1;
            end
            NX_RET:   nxt = link;
            NX_ITEST: nxt = irq_req ? INT_ENTRY : inc;
        endcase
    end

endmodule

// File: rtl/uc_sequencer.sv
module uc_sequencer
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             flag_zero,
    input  logic             flag_ovf,
    input  logic             ind_bit,
    input  logic             irq_req,
    output logic [CTL_W-1:0] ctrl_lines,
    output logic [UA_W-1:0]  uaddr
);

    logic [UA_W-1:0] car_q;
    logic [UA_W-1:0] car_d;
    logic [UA_W-1:0] link_q;
    logic [UA_W-1:0] ret_addr;
    logic            save_link;
    uword_t          cbr;

    uc_store u_store (
        .addr (car_q),
        .word (cbr)
    );

    uc_nextaddr u_next (
        .car       (car_q),
        .sel       (cbr.sel),
        .cnd       (cbr.cnd),
        .tgt       (cbr.tgt),
        .link      (link_q),
        .opcode    (opcode),
        .flag_zero (flag_zero),
        .flag_ovf  (flag_ovf),
        .ind_bit   (ind_bit),
        .irq_req   (irq_req),
        .nxt       (car_d),
        .save_link (save_link),
        .ret_addr  (ret_addr)
    );

    uc_link u_link (
        .clk    (clk),
        .rst    (rst),
        .save   (save_link),
        .ret_in (ret_addr),
        .link   (link_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= FETCH_ENTRY;
        end else begin
            car_q <= car_d;
        end
    end

    assign ctrl_lines = cbr.ctl;
    assign uaddr      = car_q;

endmodule

// File: rtl/uc_sequencer_chk.sv
module uc_sequencer_chk
    import uc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [UA_W-1:0]  car,
    input logic [2:0]       sel,
    input logic [1:0]       cnd,
    input logic [UA_W-1:0]  tgt,
    input logic [UA_W-1:0]  link,
    input logic             zero,
    input logic             irq
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(negedge clk) begin
        if (rst_q) begin
            reset_entry_chk: assert (car == FETCH_ENTRY);
        end
    end

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_SEQ) |=> (car == $past(car) + 1'b1));

    // R4
    cond_always_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_COND && cnd == CN_ALWAYS) |=> (car == $past(tgt)));

    // R4
    cond_zero_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_COND && cnd == CN_ZERO && !zero) |=> (car == $past(car) + 1'b1));

    // R5
    map_align_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_MAP) |=> (car[MAP_SHIFT-1:0] == '0 && car >= MAP_BASE));

    // R6
    call_link_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_CALL) |=> (link == $past(car) + 1'b1 && car == $past(tgt)));

    // R7
    ret_link_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_RET) |=> (car == $past(link)));

    // R8
    irq_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_ITEST && irq) |=> (car == INT_ENTRY));

    // R9
    rsv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == NX_RSV6 || sel == NX_RSV7) |=> (car == $past(car) + 1'b1));

endmodule

bind uc_sequencer uc_sequencer_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .car  (car_q),
    .sel  (cbr.sel),
    .cnd  (cbr.cnd),
    .tgt  (cbr.tgt),
    .link (link_q),
    .zero (flag_zero),
    .irq  (irq_req)
);

// File: tb/uc_sequencer_bench.sv
module uc_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = '0;
    logic        flag_zero = 1'b0;
    logic        flag_ovf = 1'b0;
    logic        ind_bit = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] ctrl_lines;
    logic [7:0]  uaddr;

    uc_sequencer u_uc_sequencer (
        .clk        (clk),
        .rst        (rst),
        .opcode     (opcode),
        .flag_zero  (flag_zero),
        .flag_ovf   (flag_ovf),
        .ind_bit    (ind_bit),
        .irq_req    (irq),
        .ctrl_lines (ctrl_lines),
        .uaddr      (uaddr)
    );

    always #4 clk = ~clk;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    logic  [7:0] exp_car  = '0;
    logic  [7:0] exp_link = '0;
    string last_tag = "R1";

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected microprogram (R10, R12): select code, condition code, target.
    function automatic void m_word(input logic [7:0] a, output int sel,
                                   output int cnd, output logic [7:0] tgt);
        int k;
        int off;
        sel = 0;
        cnd = 0;
        tgt = '0;
        if (a >= 8'h20 && a <= 8'h9F) begin
            k   = (int'(a) - 32) / 8;
            off = (int'(a) - 32) % 8;
            case (off)
                0: begin sel = 1; cnd = k % 4; tgt = a + 8'd4; end
                1: sel = (k % 2 == 0) ? 0 : (((k / 2) % 2 == 0) ? 6 : 7);
                2: begin sel = 3; tgt = 8'hF0; end
                3: sel = 5;
                4: begin sel = 1; cnd = 0; tgt = 8'h00; end
                default: sel = 0;
            endcase
        end else begin
            case (a)
                8'h02: begin sel = 1; cnd = 3; tgt = 8'h08; end
                8'h03: sel = 2;
                8'h09: begin sel = 1; cnd = 0; tgt = 8'h03; end
                8'h0D: begin sel = 1; cnd = 0; tgt = 8'h00; end
                8'hF1: sel = 4;
                default: sel = 0;
            endcase
        end
    endfunction

    function automatic void advance();
        int         sel;
        int         cnd;
        logic [7:0] tgt;
        logic       hit;
        m_word(exp_car, sel, cnd, tgt);
        case (sel)
            1: begin
                hit = (cnd == 0) || (cnd == 1 && flag_zero) ||
                      (cnd == 2 && flag_ovf) || (cnd == 3 && ind_bit);
                exp_car  = hit ? tgt : exp_car + 8'd1;
                last_tag = "R4";
            end
            2: begin
                exp_car  = 8'h20 + {1'b0, opcode, 3'b000};
                last_tag = "R5";
            end
            3: begin
                exp_link = exp_car + 8'd1;
                exp_car  = tgt;
                last_tag = "R6";
            end
            4: begin
                exp_car  = exp_link;
                last_tag = "R7";
            end
            5: begin
                exp_car  = irq ? 8'h0C : exp_car + 8'd1;
                last_tag = "R8";
            end
            6, 7: begin
                exp_car  = exp_car + 8'd1;
                last_tag = "R9";
            end
            default: begin
                exp_car  = exp_car + 8'd1;
                last_tag = "R3";
            end
        endcase
    endfunction

    task automatic cycle(input logic [3:0] op, input logic z, input logic o,
                         input logic i, input logic q);
        @(negedge clk);
        check({last_tag, " R10 R12 R11"}, {8'h00, uaddr}, {8'h00, exp_car});
        check("R2", ctrl_lines, {exp_car, exp_car ^ 8'hA5});
        opcode    = op;
        flag_zero = z;
        flag_ovf  = o;
        ind_bit   = i;
        irq       = q;
        advance();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", {8'h00, uaddr}, 16'h0000);
        check("R1 R2", ctrl_lines, 16'h00A5);
        rst      = 1'b0;
        exp_car  = 8'h00;
        exp_link = 8'h00;
        advance();
    endtask

    initial begin
        void'($urandom(32'd7321));
        do_reset();
        // Directed: every opcode under four flag/interrupt patterns.
        for (int op = 0; op < 16; op++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int c = 0; c < 14; c++) begin
                    cycle(4'(op), pat[0], pat[1], pat[0] ^ pat[1], pat[1]);
                end
            end
        end
        // Random stimulus, interrupt requests about one cycle in four.
        for (int c = 0; c < 4000; c++) begin
            cycle(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  ($urandom_range(0, 3) == 0));
        end
        // Reset in the middle of a routine (R1), then resume.
        do_reset();
        for (int c = 0; c < 60; c++) begin
            cycle(4'(c % 16), 1'b1, 1'b0, 1'b1, 1'b0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule